// File: doc/BRIEF.md
# Pin Output Controller with Set/Clear Registers

This block is a register-mapped general-purpose pin controller for up to 32 pins. A processor reaches it over a plain 32-bit register bus: an address, a write strobe, write data, and read data. Each pin owns a 3-bit mode field. Mode fields are packed ten to a word across four consecutive mode words. A pin drives its pad only while its mode field holds the output code.

Pin output levels sit in a latch bank that software never writes directly. One word raises the latches whose bits are written as ones. A second word lowers them. A zero bit in either word leaves its pin alone, so several agents can change different pins without a read-modify-write. A status word returns the level seen on every pin. For an output pin that is its own latch. For any other pin it is the external input.

Reads are combinational from the address. Writes take effect at the rising clock edge on which the strobe is high.

Top module: `pin_ctl_top`

## Requirements
- R1: A synchronous active-high reset sets every mode field to 3'b000 (input), every output latch to 0, and therefore every output-enable to 0.
- R2: The mode words sit at byte offsets 0x00, 0x04, 0x08 and 0x0C. Pin n lives in word n/10, at bits 3*(n%10)+2 down to 3*(n%10), so pin 20 is bits 2:0 of 0x08 and pin 21 is bits 5:3. A read returns the stored fields. Bits that hold no field read as 0: bits 31:30 of every word, and bits 31:6 of 0x0C.
- R3: pin_oe[n] is 1 exactly while pin n's mode field equals 3'b001. Changing a field by read-modify-write leaves the neighbouring fields and their enables intact.
- R4: A write to offset 0x1C sets the output latch of every pin whose data bit is 1. Bits written as 0, including an all-zero write, change nothing.
- R5: A write to offset 0x28 clears the output latch of every pin whose data bit is 1. Bits written as 0 change nothing.
- R6: Offsets 0x1C and 0x28 always read as zero.
- R7: Offset 0x34 reads the pin levels. Bit n is pin n's output latch when pin_oe[n] is 1, and pin_in[n] otherwise.
- R8: A cycle with bus_wr low, or a write to an offset outside the mode, set and clear words, changes no state. Reads of unmapped offsets return zero.
- R9: pin_out carries the output latch whatever the mode field holds. A latch set while its pin is an input is kept and shows once the pin is made an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Levels sensed on the external pins |
| pin_out | output | 32 | Output latch value per pin |
| pin_oe | output | 32 | Output enable per pin |

## Verification
The properties assume that bus_addr, bus_wr and bus_wdata are known on every clock edge after reset. They also assume that one access happens per cycle, so a set and a clear cannot coincide at the port. To stay inside that, the bench drives every bus input from time zero and changes them only on falling edges. It holds the strobe low throughout reset and never offers more than one address per cycle. It also keeps pin_in at a defined value, so level reads of input-mode pins stay deterministic.

// File: rtl/pin_ctl_pkg.sv
package pin_ctl_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int FIELD_W = 3;
    localparam int WORD_W  = ADDR_W - 2;

    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h34;

    localparam logic [FIELD_W-1:0] FN_INPUT  = 3'b000;
    localparam logic [FIELD_W-1:0] FN_OUTPUT = 3'b001;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_MODE,
        RD_LEVEL
    } rd_src_e;

    typedef struct packed {
        logic              mode_hit;
        logic [WORD_W-1:0] word;
        logic              set_hit;
        logic              clr_hit;
        rd_src_e           rd_src;
    } bus_dec_t;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/pin_ctl_decode.sv
module pin_ctl_decode
    import pin_ctl_pkg::*;
#(
    parameter int NUM_MODE = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_dec_t          dec
);

    always_comb begin
        dec.word     = addr[ADDR_W-1:2];
        dec.mode_hit = (addr[1:0] == 2'b00) && (int'(addr[ADDR_W-1:2]) < NUM_MODE);
        dec.set_hit  = (addr == OFS_SET);
        dec.clr_hit  = (addr == OFS_CLR);
        if (dec.mode_hit)
            dec.rd_src = RD_MODE;
        else if (addr == OFS_LEVEL)
            dec.rd_src = RD_LEVEL;
        else
            dec.rd_src = RD_ZERO;
    end

endmodule

// File: rtl/pin_mode_bank.sv
module pin_mode_bank
    import pin_ctl_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int PER_WORD = 10,
    localparam int NUM_MODE = ceil_div(NUM_PINS, PER_WORD)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   word,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_word,
    output logic [NUM_PINS-1:0] oe
);

    logic [FIELD_W-1:0] field_q [NUM_PINS];
    logic [DATA_W-1:0]  image   [NUM_MODE];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int WIDX = p / PER_WORD;
        localparam int SLOT = p % PER_WORD;

        always_ff @(posedge clk) begin
            if (rst)
                field_q[p] <= FN_INPUT;
            else if (wr_en && (int'(word) == WIDX))
                field_q[p] <= wdata[SLOT*FIELD_W +: FIELD_W];
        end

        assign oe[p] = (field_q[p] == FN_OUTPUT);
    end

    always_comb begin
        for (int r = 0; r < NUM_MODE; r++) begin
            image[r] = '0;
            for (int s = 0; s < PER_WORD; s++) begin
                if (r * PER_WORD + s < NUM_PINS)
                    image[r][s*FIELD_W +: FIELD_W] = field_q[r * PER_WORD + s];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int r = 0; r < NUM_MODE; r++) begin
            if (int'(word) == r)
                rd_word = image[r];
        end
    end

endmodule

// File: rtl/pin_level_latch.sv
module pin_level_latch
    import pin_ctl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] set_mask,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] level_q
);

    // a clear wins over a set on the same pin
    always_ff @(posedge clk) begin
        if (rst)
            level_q <= '0;
        else
            level_q <= (level_q | set_mask) & ~clr_mask;
    end

endmodule

// File: rtl/pin_ctl_top.sv
module pin_ctl_top
    import pin_ctl_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int PER_WORD = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam int NUM_MODE = ceil_div(NUM_PINS, PER_WORD);

    bus_dec_t            dec;
    logic [DATA_W-1:0]   mode_rd;
    logic [NUM_PINS-1:0] set_mask;
    logic [NUM_PINS-1:0] clr_mask;
    logic [NUM_PINS-1:0] level_now;
    logic [DATA_W-1:0]   level_word;

    pin_ctl_decode #(.NUM_MODE(NUM_MODE)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    pin_mode_bank #(.NUM_PINS(NUM_PINS), .PER_WORD(PER_WORD)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && dec.mode_hit),
        .word    (dec.word),
        .wdata   (bus_wdata),
        .rd_word (mode_rd),
        .oe      (pin_oe)
    );

    assign set_mask = (bus_wr && dec.set_hit) ? bus_wdata[NUM_PINS-1:0] : '0;
    assign clr_mask = (bus_wr && dec.clr_hit) ? bus_wdata[NUM_PINS-1:0] : '0;

    pin_level_latch #(.NUM_PINS(NUM_PINS)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .level_q  (pin_out)
    );

    assign level_now = (pin_out & pin_oe) | (pin_in & ~pin_oe);

    always_comb begin
        level_word = '0;
        level_word[NUM_PINS-1:0] = level_now;
    end

    always_comb begin
        unique case (dec.rd_src)
            RD_MODE:  bus_rdata = mode_rd;
            RD_LEVEL: bus_rdata = level_word;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pin_ctl_checker.sv
module pin_ctl_checker
    import pin_ctl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);

    p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SET)
        |=> ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

    p_clear_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CLR)
        |=> ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == '0));

    p_zero_bits_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SET)
        |=> ((pin_out & ~$past(bus_wdata[NUM_PINS-1:0])) == ($past(pin_out) & ~$past(bus_wdata[NUM_PINS-1:0]))));

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == OFS_SET || bus_addr == OFS_CLR))
        |=> $stable(pin_out));

    p_oe_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr < 8'h10)
        |=> $stable(pin_oe));

    p_strobe_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_SET || bus_addr == OFS_CLR) |-> (bus_rdata == '0));

endmodule

bind pin_ctl_top pin_ctl_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tb_pin_ctl_top.sv
`timescale 1ns/1ps
module tb_pin_ctl_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pin_ctl_top dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  addr;
        logic [31:0] data;   // write data, or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h08, 32'h0000_0009, 4'd2},  // R2: pins 20 and 21 become outputs
        '{1'b0, 8'h08, 32'h0000_0009, 4'd2},  // R2
        '{1'b1, 8'h1C, 32'h0030_0000, 4'd4},  // R4
        '{1'b0, 8'h34, 32'h0030_0000, 4'd7},  // R7
        '{1'b0, 8'h1C, 32'h0000_0000, 4'd6},  // R6
        '{1'b0, 8'h28, 32'h0000_0000, 4'd6},  // R6
        '{1'b1, 8'h28, 32'h0010_0000, 4'd5},  // R5
        '{1'b0, 8'h34, 32'h0020_0000, 4'd5},  // R5
        '{1'b1, 8'h1C, 32'h0000_0000, 4'd4},  // R4: zero write
        '{1'b0, 8'h34, 32'h0020_0000, 4'd4},  // R4
        '{1'b1, 8'h0C, 32'hFFFF_FFFF, 4'd2},  // R2
        '{1'b0, 8'h0C, 32'h0000_003F, 4'd2},  // R2
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 4'd2},  // R2
        '{1'b0, 8'h00, 32'h3FFF_FFFF, 4'd2},  // R2
        '{1'b1, 8'h40, 32'hFFFF_FFFF, 4'd8},  // R8: unmapped write
        '{1'b0, 8'h40, 32'h0000_0000, 4'd8},  // R8
        '{1'b0, 8'h08, 32'h0000_0009, 4'd8}   // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        do_reset();
        // R1: reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        bus_read(8'h08, rd);
        check("R1 mode word", rd, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].is_wr)
                bus_write(VEC[i].addr, VEC[i].data);
            else begin
                bus_read(VEC[i].addr, rd);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].data);
            end
        end

        @(negedge clk);
        check("R3 oe after table", pin_oe, 32'h0030_0000);
        check("R9 out after table", pin_out, 32'h0020_0000);

        // R3: read-modify-write turns pin 20 to input, pin 21 stays output
        bus_read(8'h08, rd);
        bus_write(8'h08, (rd & ~32'h7));
        check("R3 oe after rmw", pin_oe, 32'h0020_0000);
        bus_read(8'h08, rd);
        check("R3 neighbour field", rd, 32'h0000_0008);

        // R9: latch set on an input pin is kept
        bus_write(8'h1C, 32'h0010_0000);
        check("R9 out while input", pin_out, 32'h0030_0000);

        // R7: level mixes latch (output pins) and pin_in (input pins)
        pin_in = 32'h0000_0000;
        bus_read(8'h34, rd);
        check("R7 level in=0", rd, 32'h0020_0000);
        pin_in = 32'h0000_FFFF;
        bus_read(8'h34, rd);
        check("R7 level in=ffff", rd, 32'h0020_FFFF);

        // R9: make pin 20 an output again, kept latch shows
        bus_write(8'h08, 32'h0000_0009);
        pin_in = 32'h0;
        bus_read(8'h34, rd);
        check("R9 kept latch visible", rd, 32'h0030_0000);

        // R8: strobe low leaves everything alone
        @(negedge clk);
        bus_addr  = 8'h28;
        bus_wdata = 32'hFFFF_FFFF;
        bus_wr    = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 no write out", pin_out, 32'h0030_0000);
        check("R8 no write oe", pin_oe, 32'h0030_0000);

        // R1: reset in mid-run
        do_reset();
        check("R1 out after rerun", pin_out, 32'h0);
        check("R1 oe after rerun", pin_oe, 32'h0);
        bus_read(8'h00, rd);
        check("R1 word0 after rerun", rd, 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule